// File: doc/BRIEF.md
# 16-bit ALU with Registered Condition Flags

This block is the arithmetic and logic stage of a small 16-bit accumulator-style processor. An already selected destination value and source value arrive together with a four-bit operation code and a strobe that marks the operation as valid. In the same cycle the block produces the 16-bit result and three flags that tell the surrounding datapath what to do with it. One flag asks for a write back into the register file. One asks for a store to memory. One reports an operation code the block does not know.

The block keeps four condition flags in a status register: negative, zero, signed-less-than and carry. Add-type and subtract-type operations recompute all four. Bitwise operations, negate, load and test recompute only negative and zero. Store leaves all four flags alone. Any operation whose destination is the program counter also leaves all four flags alone.

The next status value is also driven out combinationally. Sequencing logic can therefore see the flags before the clock edge that stores them. The carry input comes from outside the block, so the sequencer decides which carry the with-carry operations see.

Top module: `alu16_core`

## Requirements
- R1: Opcode 0 (add) gives dst+src, and opcode 1 (add with carry) gives dst+src+carry_in. The carry flag is set when the unmasked sum needs a 17th bit.
- R2: Opcode 2 (subtract) and opcode 4 (compare) compute dst + ~src + 1. Opcode 3 (subtract with carry) computes dst + ~src + carry_in. A set carry flag after any of these means no borrow occurred.
- R3: For opcodes 0 to 4, the signed-less-than flag is set exactly when dst, read as two's complement, is less than src, read as two's complement. It does not depend on the sign of the result.
- R4: The negative flag is result bit 15, and the zero flag is set when the 16-bit result is zero. In the 16-bit status word, negative is bit 9, zero is bit 8, signed-less-than is bit 7 and carry is bit 6. All other bits of the status word are 0.
- R5: Opcode 6 (negate, result -src), 8 (XOR), 9 (load, result src), A (OR), B (AND) and C (test, dst AND src) update only the negative and zero flags. They hold signed-less-than and carry.
- R6: Compare (4) and test (C) never raise wb_en. They still update their flags.
- R7: Store (D) raises store_req, drives dst on result, keeps wb_en low and changes no flag.
- R8: When dst_is_pc is high, no flag changes. Write back still follows the opcode.
- R9: Opcodes 5, 7, E and F raise illegal_op. They keep wb_en and store_req low, drive result to 0 and change no flag.
- R10: The status register loads only in cycles where op_valid is high. Reset clears it to 0. When op_valid is low, wb_en, store_req and illegal_op are low.
- R11: status_nxt equals the value that status_q takes on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation code |
| dst_val | input | 16 | Destination register value (operand a) |
| src_val | input | 16 | Source value (operand b) |
| carry_in | input | 1 | Carry used by the with-carry operations |
| dst_is_pc | input | 1 | Destination is the program counter |
| result | output | 16 | Result, or store data for opcode D |
| wb_en | output | 1 | Write result to the destination register |
| store_req | output | 1 | Write result to memory |
| illegal_op | output | 1 | Unknown opcode presented |
| status_nxt | output | 16 | Status word to be loaded at the next edge |
| status_q | output | 16 | Registered status word |

## Verification
A wrong flag class, for example a bitwise operation that overwrites the carry, is not visible in the result. It shows up on status_nxt in the same cycle and on status_q one edge later. The bench catches it by first setting signed-less-than and carry, then running every NZ-only operation and reading those two bits back. A missing suppression for the program counter, store or an illegal opcode appears as a status_q change one cycle after the operation. An error in the carry or borrow polarity shows in bit 6 right after a single subtract. A signed-less-than flag wrongly tied to the result sign shows on the 0x8000 minus 1 case, where the result is positive but the flag must be set.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int STAT_W  = 16;
  localparam int POS_NEG = 9;
  localparam int POS_ZER = 8;
  localparam int POS_SLT = 7;
  localparam int POS_CRY = 6;

  localparam logic [3:0] OPC_ADD  = 4'h0;
  localparam logic [3:0] OPC_ADC  = 4'h1;
  localparam logic [3:0] OPC_SUB  = 4'h2;
  localparam logic [3:0] OPC_SBC  = 4'h3;
  localparam logic [3:0] OPC_CMP  = 4'h4;
  localparam logic [3:0] OPC_NEG  = 4'h6;
  localparam logic [3:0] OPC_XOR  = 4'h8;
  localparam logic [3:0] OPC_LD   = 4'h9;
  localparam logic [3:0] OPC_OR   = 4'hA;
  localparam logic [3:0] OPC_AND  = 4'hB;
  localparam logic [3:0] OPC_TST  = 4'hC;
  localparam logic [3:0] OPC_ST   = 4'hD;

  typedef enum logic [1:0] {
    FCLS_NONE = 2'd0,
    FCLS_NZ   = 2'd1,
    FCLS_ALL  = 2'd2
  } fcls_e;

  typedef struct packed {
    logic neg;
    logic zer;
    logic slt;
    logic cry;
  } cond_t;

  function automatic logic [STAT_W-1:0] pack_status(input cond_t f);
    logic [STAT_W-1:0] w;
    w          = '0;
    w[POS_NEG] = f.neg;
    w[POS_ZER] = f.zer;
    w[POS_SLT] = f.slt;
    w[POS_CRY] = f.cry;
    return w;
  endfunction

  function automatic cond_t unpack_status(input logic [STAT_W-1:0] w);
    cond_t f;
    f.neg = w[POS_NEG];
    f.zer = w[POS_ZER];
    f.slt = w[POS_SLT];
    f.cry = w[POS_CRY];
    return f;
  endfunction

endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
  import alu16_pkg::*;
(
  input  logic [3:0] opcode,
  output logic       is_arith,
  output logic       is_sub,
  output logic       use_cin,
  output fcls_e      fcls,
  output logic       writes,
  output logic       stores,
  output logic       illegal
);

  always_comb begin
    is_arith = 1'b0;
    is_sub   = 1'b0;
    use_cin  = 1'b0;
    fcls     = FCLS_NONE;
    writes   = 1'b0;
    stores   = 1'b0;
    illegal  = 1'b0;
    case (opcode)
      OPC_ADD: begin is_arith = 1'b1; fcls = FCLS_ALL; writes = 1'b1; end
      OPC_ADC: begin is_arith = 1'b1; use_cin = 1'b1; fcls = FCLS_ALL; writes = 1'b1; end
      OPC_SUB: begin is_arith = 1'b1; is_sub = 1'b1; fcls = FCLS_ALL; writes = 1'b1; end
      OPC_SBC: begin is_arith = 1'b1; is_sub = 1'b1; use_cin = 1'b1; fcls = FCLS_ALL; writes = 1'b1; end
      OPC_CMP: begin is_arith = 1'b1; is_sub = 1'b1; fcls = FCLS_ALL; end
      OPC_NEG, OPC_XOR, OPC_LD, OPC_OR, OPC_AND: begin fcls = FCLS_NZ; writes = 1'b1; end
      OPC_TST: begin fcls = FCLS_NZ; end
      OPC_ST:  begin stores = 1'b1; end
      default: begin illegal = 1'b1; end
    endcase
  end

endmodule

// File: rtl/alu16_arith.sv
module alu16_arith #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_sub,
  input  logic              use_cin,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              slt
);

  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] a_ext;
  logic [EXT_W-1:0] b_ext;
  logic [EXT_W-1:0] c_ext;
  logic [EXT_W-1:0] total;
  logic             c_eff;

  always_comb begin
    c_eff = use_cin ? cin : is_sub;
    a_ext = {1'b0, a};
    b_ext = is_sub ? {1'b0, ~b} : {1'b0, b};
    c_ext = {{DATA_W{1'b0}}, c_eff};
    total = a_ext + b_ext + c_ext;
    sum   = total[DATA_W-1:0];
    cout  = total[DATA_W];
    slt   = $signed(a) < $signed(b);
  end

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);

  always_comb begin
    case (opcode)
      OPC_NEG:          res = '0 - b;
      OPC_XOR:          res = a ^ b;
      OPC_LD:           res = b;
      OPC_OR:           res = a | b;
      OPC_AND, OPC_TST: res = a & b;
      OPC_ST:           res = a;
      default:          res = '0;
    endcase
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic              carry_in,
  input  logic              dst_is_pc,
  output logic [DATA_W-1:0] result,
  output logic              wb_en,
  output logic              store_req,
  output logic              illegal_op,
  output logic [STAT_W-1:0] status_nxt,
  output logic [STAT_W-1:0] status_q
);

  logic              d_arith, d_sub, d_cin, d_wr, d_st, d_ill;
  fcls_e             d_fcls;
  logic [DATA_W-1:0] ar_sum, lg_res, res_w;
  logic              ar_cout, ar_slt;
  cond_t             held, fresh, nxt;
  logic              upd_en;
  logic [STAT_W-1:0] stat_d;

  alu16_decode u_dec (
    .opcode   (opcode),
    .is_arith (d_arith),
    .is_sub   (d_sub),
    .use_cin  (d_cin),
    .fcls     (d_fcls),
    .writes   (d_wr),
    .stores   (d_st),
    .illegal  (d_ill)
  );

  alu16_arith #(.DATA_W(DATA_W)) u_ar (
    .a       (dst_val),
    .b       (src_val),
    .is_sub  (d_sub),
    .use_cin (d_cin),
    .cin     (carry_in),
    .sum     (ar_sum),
    .cout    (ar_cout),
    .slt     (ar_slt)
  );

  alu16_logic #(.DATA_W(DATA_W)) u_lg (
    .opcode (opcode),
    .a      (dst_val),
    .b      (src_val),
    .res    (lg_res)
  );

  // result and strobes
  always_comb begin
    res_w      = d_arith ? ar_sum : lg_res;
    result     = d_ill ? '0 : res_w;
    wb_en      = op_valid & d_wr;
    store_req  = op_valid & d_st;
    illegal_op = op_valid & d_ill;
  end

  // next flag value
  always_comb begin
    held      = unpack_status(status_q);
    fresh.neg = res_w[DATA_W-1];
    fresh.zer = (res_w == '0);
    fresh.slt = ar_slt;
    fresh.cry = ar_cout;
    upd_en    = op_valid & ~dst_is_pc & ~d_ill;
    nxt       = held;
    if (upd_en) begin
      case (d_fcls)
        FCLS_ALL: nxt = fresh;
        FCLS_NZ: begin
          nxt.neg = fresh.neg;
          nxt.zer = fresh.zer;
        end
        default: nxt = held;
      endcase
    end
    stat_d     = pack_status(nxt);
    status_nxt = stat_d;
  end

  // status register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (op_valid) begin
      status_q <= stat_d;
    end
  end

endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        opcode,
  input logic [DATA_W-1:0] dst_val,
  input logic              dst_is_pc,
  input logic [DATA_W-1:0] result,
  input logic              wb_en,
  input logic              store_req,
  input logic              illegal_op,
  input logic [STAT_W-1:0] status_nxt,
  input logic [STAT_W-1:0] status_q
);

  logic nz_only;
  assign nz_only = (opcode == 4'h6) || (opcode == 4'h8) || (opcode == 4'h9) ||
                   (opcode == 4'hA) || (opcode == 4'hB) || (opcode == 4'hC);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(status_q));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !wb_en && !store_req && !illegal_op);

  p_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> status_q == $past(status_nxt));

  p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && dst_is_pc |=> $stable(status_q));

  p_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> !wb_en && result == dst_val);

  p_store_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> $stable(status_q));

  p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> !wb_en && !store_req && result == '0);

  p_illegal_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> $stable(status_q));

  p_no_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (opcode == 4'h4 || opcode == 4'hC) |-> !wb_en);

  p_sc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && nz_only |=> $stable(status_q[POS_SLT]) && $stable(status_q[POS_CRY]));

  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en && !dst_is_pc |=> status_q[POS_ZER] == ($past(result) == '0));

  p_spare_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> $countones(status_q) <= 4 &&
             (status_q & ~(16'h0200 | 16'h0100 | 16'h0080 | 16'h0040)) == '0);

endmodule

bind alu16_core alu16_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .opcode     (opcode),
  .dst_val    (dst_val),
  .dst_is_pc  (dst_is_pc),
  .result     (result),
  .wb_en      (wb_en),
  .store_req  (store_req),
  .illegal_op (illegal_op),
  .status_nxt (status_nxt),
  .status_q   (status_q)
);

// File: tb/alu16_core_tb.sv
module alu16_core_tb_top;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  opcode;
  logic [15:0] dst_val;
  logic [15:0] src_val;
  logic        carry_in;
  logic        dst_is_pc;
  logic [15:0] result;
  logic        wb_en;
  logic        store_req;
  logic        illegal_op;
  logic [15:0] status_nxt;
  logic [15:0] status_q;

  int total_cnt = 0;
  int bad_cnt   = 0;

  alu16_core dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .opcode     (opcode),
    .dst_val    (dst_val),
    .src_val    (src_val),
    .carry_in   (carry_in),
    .dst_is_pc  (dst_is_pc),
    .result     (result),
    .wb_en      (wb_en),
    .store_req  (store_req),
    .illegal_op (illegal_op),
    .status_nxt (status_nxt),
    .status_q   (status_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at falling edge, check combinational outputs, then registered status
  task automatic run_op(input string tag, input logic vld, input logic [3:0] opc,
                        input logic [15:0] a, input logic [15:0] b, input logic ci,
                        input logic pc, input logic [15:0] exp_res, input logic exp_wb,
                        input logic exp_st, input logic exp_ill, input logic [15:0] exp_stat);
    @(negedge clk);
    op_valid  = vld;
    opcode    = opc;
    dst_val   = a;
    src_val   = b;
    carry_in  = ci;
    dst_is_pc = pc;
    #1;
    chk({tag, " result"}, result, exp_res);
    chk({tag, " wb_en"}, {15'd0, wb_en}, {15'd0, exp_wb});
    chk({tag, " store_req"}, {15'd0, store_req}, {15'd0, exp_st});
    chk({tag, " illegal_op"}, {15'd0, illegal_op}, {15'd0, exp_ill});
    chk({tag, " status_nxt R11"}, status_nxt, exp_stat);
    @(posedge clk);
    #1;
    chk({tag, " status_q"}, status_q, exp_stat);
    op_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    op_valid = 1'b0; opcode = 4'h0; dst_val = '0; src_val = '0;
    carry_in = 1'b0; dst_is_pc = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R10 reset status", status_q, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_add;
    run_op("R1 R4 add to 0x8000", 1, 4'h0, 16'h7FFF, 16'h0001, 0, 0, 16'h8000, 1, 0, 0, 16'h0200);
    run_op("R1 R3 add wrap carry", 1, 4'h0, 16'hFFFF, 16'h0001, 0, 0, 16'h0000, 1, 0, 0, 16'h01C0);
    run_op("R1 adc carry in", 1, 4'h1, 16'h0001, 16'h0002, 1, 0, 16'h0004, 1, 0, 0, 16'h0080);
    run_op("R1 adc no carry", 1, 4'h1, 16'h1234, 16'h0001, 0, 0, 16'h1235, 1, 0, 0, 16'h0000);
  endtask

  task automatic t_sub;
    run_op("R2 sub no borrow", 1, 4'h2, 16'h0005, 16'h0003, 0, 0, 16'h0002, 1, 0, 0, 16'h0040);
    run_op("R2 R3 sub borrow", 1, 4'h2, 16'h0003, 16'h0005, 0, 0, 16'hFFFE, 1, 0, 0, 16'h0280);
    run_op("R2 sbc borrow in", 1, 4'h3, 16'h0005, 16'h0003, 0, 0, 16'h0001, 1, 0, 0, 16'h0040);
    run_op("R2 sbc zero", 1, 4'h3, 16'h0005, 16'h0005, 1, 0, 16'h0000, 1, 0, 0, 16'h0140);
    run_op("R3 slt vs result sign", 1, 4'h2, 16'h8000, 16'h0001, 0, 0, 16'h7FFF, 1, 0, 0, 16'h00C0);
    run_op("R6 compare equal", 1, 4'h4, 16'h0007, 16'h0007, 0, 0, 16'h0000, 0, 0, 0, 16'h0140);
  endtask

  task automatic t_logic;
    run_op("R5 set S and C", 1, 4'h2, 16'h8000, 16'h0001, 0, 0, 16'h7FFF, 1, 0, 0, 16'h00C0);
    run_op("R5 xor zero", 1, 4'h8, 16'h00FF, 16'h00FF, 0, 0, 16'h0000, 1, 0, 0, 16'h01C0);
    run_op("R5 or neg", 1, 4'hA, 16'h8000, 16'h0001, 1, 0, 16'h8001, 1, 0, 0, 16'h02C0);
    run_op("R5 and zero", 1, 4'hB, 16'hF0F0, 16'h0F0F, 0, 0, 16'h0000, 1, 0, 0, 16'h01C0);
    run_op("R5 load", 1, 4'h9, 16'h1111, 16'h8000, 0, 0, 16'h8000, 1, 0, 0, 16'h02C0);
    run_op("R5 negate one", 1, 4'h6, 16'h0000, 16'h0001, 0, 0, 16'hFFFF, 1, 0, 0, 16'h02C0);
    run_op("R5 negate zero", 1, 4'h6, 16'h1234, 16'h0000, 0, 0, 16'h0000, 1, 0, 0, 16'h01C0);
    run_op("R6 test no wb", 1, 4'hC, 16'h8000, 16'h8000, 0, 0, 16'h8000, 0, 0, 0, 16'h02C0);
  endtask

  task automatic t_store_pc;
    run_op("R7 store", 1, 4'hD, 16'hBEEF, 16'h0000, 0, 0, 16'hBEEF, 0, 1, 0, 16'h02C0);
    run_op("R8 pc dest add", 1, 4'h0, 16'hFFFF, 16'h0001, 0, 1, 16'h0000, 1, 0, 0, 16'h02C0);
    run_op("R8 pc dest xor", 1, 4'h8, 16'h0001, 16'h0001, 0, 1, 16'h0000, 1, 0, 0, 16'h02C0);
  endtask

  task automatic t_illegal;
    run_op("R9 opcode 5", 1, 4'h5, 16'hFFFF, 16'h0001, 0, 0, 16'h0000, 0, 0, 1, 16'h02C0);
    run_op("R9 opcode 7", 1, 4'h7, 16'h0000, 16'h0000, 0, 0, 16'h0000, 0, 0, 1, 16'h02C0);
    run_op("R9 opcode E", 1, 4'hE, 16'h0003, 16'h0005, 0, 0, 16'h0000, 0, 0, 1, 16'h02C0);
    run_op("R9 opcode F", 1, 4'hF, 16'h1234, 16'h1234, 1, 0, 16'h0000, 0, 0, 1, 16'h02C0);
  endtask

  task automatic t_idle;
    run_op("R10 idle add", 0, 4'h0, 16'hFFFF, 16'h0001, 0, 0, 16'h0000, 0, 0, 0, 16'h02C0);
    run_op("R10 idle store", 0, 4'hD, 16'h5555, 16'h0000, 0, 0, 16'h5555, 0, 0, 0, 16'h02C0);
    @(negedge clk) rst_n = 1'b0;
    #1 chk("R10 async clear", status_q, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    run_op("R10 after reset", 1, 4'h9, 16'h0000, 16'h0001, 0, 0, 16'h0001, 1, 0, 0, 16'h0000);
  endtask

  initial begin
    #(5.0 * 100000);
    bad_cnt++;
    total_cnt++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_store_pc();
    t_illegal();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end

endmodule